// File: doc/BRIEF.md
# Record Region Write Controller

This block takes a stream of sample words from a ready/valid source and stores them in an external word-addressed memory. It drives a small burst write interface that has a request channel, a data channel and a response strobe. Software places a region in memory with a byte base and a byte size, then issues a restart. From then on the block computes each burst's address and length and passes input words straight through to the memory data channel. It counts the bytes that the memory has acknowledged. When the region is full it stops asking for data.

Data past the end of the region is never dropped. Once the acknowledged count reaches the region size, the input simply stays not-ready and words wait upstream. Software reads the fullness through the register port. A later restart rewinds the write pointer and clears the count. Base and size writes only go to shadow registers, and the next restart copies them into use.

Top module: `rec_buf_ctrl`

## Requirements
- R1: After reset, and until the first restart, `in_ready` and `mw_req_valid` are low and the fullness register (read address 2) reads 0.
- R2: Register map. Address 0 is the base byte address and address 1 is the size in bytes; both read back the value written. A write to address 2 with bit 0 set is a restart. A read of address 2 returns fullness in bytes.
- R3: Accepted words are written in arrival order to consecutive word addresses. The first word goes to the base with its sub-word bits cleared.
- R4: Each burst request has a length of 1 to `MAX_BURST` words. It never crosses a `PAGE_BYTES` (4 KiB) boundary and never runs past the end of the region.
- R5: Fullness grows by burst length times word bytes only when the write response for that burst arrives. Accepting words at the input does not change it.
- R6: When fullness equals the region size, `in_ready` stays low and no request is issued. The number of accepted words equals the region size in words, and no word is lost.
- R7: A restart sets fullness to 0 and makes the next word land at the base address.
- R8: Writing base or size changes nothing until the next restart. A full region stays full and recording keeps its old place.
- R9: A restart that arrives while a burst is outstanding takes effect only after that burst's write response. The burst still completes at its old addresses.
- R10: A size that is not a whole number of words is rounded down to whole words (64-bit words by default, so 60 bytes records 56).
- R11: A request holds its address and length stable while `mw_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | REG_W | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | REG_W | Register read data (combinational) |
| in_data | input | DATA_W | Input sample word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word taken this cycle |
| mw_req_valid | output | 1 | Burst request valid |
| mw_req_ready | input | 1 | Burst request accepted |
| mw_req_addr | output | ADDR_W | Burst start byte address |
| mw_req_len | output | LEN_W | Burst length in words |
| mw_dat_valid | output | 1 | Write data valid |
| mw_dat_ready | input | 1 | Write data accepted |
| mw_dat | output | DATA_W | Write data word |
| mw_dat_last | output | 1 | Last word of the burst |
| mw_resp_valid | input | 1 | One-cycle write response for the outstanding burst |

## Verification
The case that needs care is a restart command arriving while the write response of an issued burst is still pending. In that case the restart and the fullness update want the same state. The bench holds the response back in its memory model, writes a new base and size, issues the restart, and then releases the response. It judges the result in three ways. The old burst's last word must be present at the old address. Fullness must read 0 after the response rather than the old burst's byte count. The next words must land at the new base.

// File: rtl/rbc_pkg.sv
`timescale 1ns/1ps
package rbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_RESP
    } rbc_state_e;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_SIZE = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;

endpackage

// File: rtl/rbc_regs.sv
`timescale 1ns/1ps
module rbc_regs #(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [ADDR_W:0]   fill_bytes,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W:0]   size_o,
    output logic              restart_o,
    output logic [REG_W-1:0]  rd_data
);
    import rbc_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   size;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:ADDR_W+1];

    always_comb begin
        sh_d = sh_q;
        if (wr_en) begin
            case (wr_addr)
                REG_BASE: sh_d.base = wr_data[ADDR_W-1:0];
                REG_SIZE: sh_d.size = wr_data[ADDR_W:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign base_o    = sh_q.base;
    assign size_o    = sh_q.size;
    assign restart_o = wr_en && (wr_addr == REG_CTRL) && wr_data[0];

    always_comb begin
        case (rd_addr)
            REG_BASE: rd_data = REG_W'(sh_q.base);
            REG_SIZE: rd_data = REG_W'(sh_q.size);
            REG_CTRL: rd_data = REG_W'(fill_bytes);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rbc_burst_plan.sv
`timescale 1ns/1ps
module rbc_burst_plan #(
    parameter int ADDR_W    = 14,
    parameter int WB_LG     = 3,
    parameter int PAGE_LG   = 12,
    parameter int MAX_BURST = 8,
    parameter int CNT_W     = 12,
    parameter int LEN_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  remain,
    output logic [LEN_W-1:0]  len
);
    localparam int CMP_W = CNT_W + PAGE_LG + LEN_W;

    logic [CMP_W-1:0] pg_w, rem_w, cap_w, m1, m2;

    generate
        if (ADDR_W > PAGE_LG) begin : g_paged
            logic [PAGE_LG:0] pg_bytes;
            logic             unused_top;
            assign unused_top = ^addr[ADDR_W-1:PAGE_LG];
            assign pg_bytes   = {1'b1, {PAGE_LG{1'b0}}} - {1'b0, addr[PAGE_LG-1:0]};
            assign pg_w       = CMP_W'(pg_bytes >> WB_LG);
        end else begin : g_flat
            logic unused_addr;
            assign unused_addr = ^addr;
            assign pg_w        = {CMP_W{1'b1}};
        end
    endgenerate

    always_comb begin
        rem_w = CMP_W'(remain);
        cap_w = CMP_W'(MAX_BURST);
        m1    = (pg_w < rem_w) ? pg_w : rem_w;
        m2    = (m1 < cap_w) ? m1 : cap_w;
        len   = LEN_W'(m2);
    end

endmodule

// File: rtl/rec_buf_ctrl.sv
`timescale 1ns/1ps
module rec_buf_ctrl #(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 14,
    parameter int MAX_BURST  = 8,
    parameter int PAGE_BYTES = 4096,
    parameter int REG_W      = 32,
    localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic [1:0]        reg_rd_addr,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              mw_req_valid,
    input  logic              mw_req_ready,
    output logic [ADDR_W-1:0] mw_req_addr,
    output logic [LEN_W-1:0]  mw_req_len,
    output logic              mw_dat_valid,
    input  logic              mw_dat_ready,
    output logic [DATA_W-1:0] mw_dat,
    output logic              mw_dat_last,
    input  logic              mw_resp_valid
);
    import rbc_pkg::*;

    localparam int WB      = DATA_W / 8;
    localparam int WB_LG   = $clog2(WB);
    localparam int PAGE_LG = $clog2(PAGE_BYTES);
    localparam int CNT_W   = ADDR_W - WB_LG + 1;
    localparam int SZ_W    = ADDR_W + 1;

    typedef struct packed {
        rbc_state_e        state;
        logic              armed;
        logic              pend;
        logic [ADDR_W-1:0] base_a;
        logic [CNT_W-1:0]  region_w;
        logic [CNT_W-1:0]  fill_w;
        logic [ADDR_W-1:0] req_addr;
        logic [LEN_W-1:0]  req_len;
        logic [LEN_W-1:0]  beats;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [ADDR_W-1:0] base_sh;
    logic [SZ_W-1:0]   size_sh;
    logic              restart_req;
    logic [SZ_W-1:0]   fill_bytes;
    logic [CNT_W-1:0]  remain;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  plan_len;
    logic              unused_low;

    assign unused_low = ^{base_sh[WB_LG-1:0], size_sh[WB_LG-1:0]};

    rbc_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .fill_bytes (fill_bytes),
        .base_o     (base_sh),
        .size_o     (size_sh),
        .restart_o  (restart_req),
        .rd_data    (reg_rd_data)
    );

    assign fill_bytes = {st_q.fill_w, {WB_LG{1'b0}}};
    assign remain     = st_q.region_w - st_q.fill_w;
    assign cur_addr   = st_q.base_a + fill_bytes[ADDR_W-1:0];

    rbc_burst_plan #(
        .ADDR_W    (ADDR_W),
        .WB_LG     (WB_LG),
        .PAGE_LG   (PAGE_LG),
        .MAX_BURST (MAX_BURST),
        .CNT_W     (CNT_W),
        .LEN_W     (LEN_W)
    ) u_plan (
        .addr   (cur_addr),
        .remain (remain),
        .len    (plan_len)
    );

    always_comb begin
        st_d = st_q;
        if (restart_req && (st_q.state != ST_IDLE)) st_d.pend = 1'b1;
        case (st_q.state)
            ST_IDLE: begin
                if (restart_req || st_q.pend) begin
                    st_d.base_a   = {base_sh[ADDR_W-1:WB_LG], {WB_LG{1'b0}}};
                    st_d.region_w = size_sh[SZ_W-1:WB_LG];
                    st_d.fill_w   = '0;
                    st_d.armed    = 1'b1;
                    st_d.pend     = 1'b0;
                end else if (st_q.armed && (remain != '0) && in_valid) begin
                    st_d.req_addr = cur_addr;
                    st_d.req_len  = plan_len;
                    st_d.state    = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mw_req_ready) begin
                    st_d.beats = st_q.req_len;
                    st_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (in_valid && mw_dat_ready) begin
                    st_d.beats = st_q.beats - 1'b1;
                    if (st_q.beats == LEN_W'(1)) st_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (mw_resp_valid) begin
                    st_d.fill_w = st_q.fill_w + CNT_W'(st_q.req_len);
                    st_d.state  = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mw_req_valid = (st_q.state == ST_REQ);
    assign mw_req_addr  = st_q.req_addr;
    assign mw_req_len   = st_q.req_len;
    assign mw_dat_valid = (st_q.state == ST_DATA) && in_valid;
    assign mw_dat       = in_data;
    assign mw_dat_last  = (st_q.beats == LEN_W'(1));
    assign in_ready     = (st_q.state == ST_DATA) && mw_dat_ready;

    logic [31:0] chk_pg_end;
    assign chk_pg_end = 32'(mw_req_addr % PAGE_BYTES) + 32'(mw_req_len) * 32'(WB);

    // R4: request length within limits
    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req_valid |-> (mw_req_len != '0) && (32'(mw_req_len) <= 32'(MAX_BURST)));

    // R4: no burst crosses a page
    a_r4_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req_valid |-> (chk_pg_end <= 32'(PAGE_BYTES)));

    // R4: no burst runs past the region end
    a_r4_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req_valid |-> ((SZ_W)'(st_q.fill_w) + (SZ_W)'(mw_req_len) <= (SZ_W)'(st_q.region_w)));

    // R6: full region holds off the input
    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill_w == st_q.region_w) |-> !in_ready);

    // R5: accepting data leaves fullness untouched
    a_r5_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_DATA) |=> $stable(st_q.fill_w));

    // R5: a response adds exactly the burst length
    a_r5_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_RESP && mw_resp_valid) |=>
            (st_q.fill_w == $past(st_q.fill_w) + CNT_W'($past(st_q.req_len))));

    // R11: request is held until taken
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req_valid && !mw_req_ready) |=>
            (mw_req_valid && $stable(mw_req_addr) && $stable(mw_req_len)));

endmodule

// File: tb/rec_buf_ctrl_test.sv
`timescale 1ns/1ps
module rec_buf_ctrl_test;
    localparam int DW = 64;
    localparam int AW = 14;
    localparam int MB = 8;
    localparam int LW = $clog2(MB + 1);
    localparam int NV = 5;

    // vector table: base, size bytes, words offered, words expected, bursts, first burst length
    localparam int V_BASE [NV] = '{32'h0000, 32'h1000, 32'h1FE0, 32'h0800, 32'h3000};
    localparam int V_SIZE [NV] = '{64, 200, 96, 60, 24};
    localparam int V_OFFR [NV] = '{8, 30, 12, 10, 3};
    localparam int V_WRDS [NV] = '{8, 25, 12, 7, 3};
    localparam int V_NB   [NV] = '{1, 4, 2, 1, 1};
    localparam int V_FRST [NV] = '{8, 8, 4, 7, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_addr = '0;
    logic [31:0]   reg_wr_data = '0;
    logic [1:0]    reg_rd_addr = '0;
    logic [31:0]   reg_rd_data;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          mw_req_valid;
    logic          mw_req_ready;
    logic [AW-1:0] mw_req_addr;
    logic [LW-1:0] mw_req_len;
    logic          mw_dat_valid;
    logic          mw_dat_ready;
    logic [DW-1:0] mw_dat;
    logic          mw_dat_last;
    logic          mw_resp_valid;

    always #2.5 clk = ~clk;

    rec_buf_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .mw_req_valid(mw_req_valid), .mw_req_ready(mw_req_ready),
        .mw_req_addr(mw_req_addr), .mw_req_len(mw_req_len),
        .mw_dat_valid(mw_dat_valid), .mw_dat_ready(mw_dat_ready),
        .mw_dat(mw_dat), .mw_dat_last(mw_dat_last), .mw_resp_valid(mw_resp_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural memory
    logic [DW-1:0] mem [0:2047];
    int  tick = 0;
    int  cur_word = 0;
    int  beat = 0;
    int  resp_cnt = 0;
    bit  hold_resp = 1'b0;
    int  blen [0:15];
    int  nb = 0;
    int  hs_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            tick          <= 0;
            mw_req_ready  <= 1'b0;
            mw_dat_ready  <= 1'b0;
            mw_resp_valid <= 1'b0;
            resp_cnt      <= 0;
            beat          <= 0;
        end else begin
            tick         <= tick + 1;
            mw_req_ready <= (tick % 3) != 0;
            mw_dat_ready <= (tick % 4) != 1;
            if (in_valid && in_ready) hs_cnt++;
            if (mw_req_valid && mw_req_ready) begin
                cur_word <= int'(mw_req_addr) / 8;
                beat     <= 0;
                check((mw_req_len != 0) && (int'(mw_req_len) <= MB), "R4 len",
                      64'(mw_req_len), 64'(MB));
                check((int'(mw_req_addr) % 4096) + int'(mw_req_len) * 8 <= 4096, "R4 page",
                      64'(mw_req_addr), 64'(mw_req_len));
                if (nb < 16) blen[nb] = int'(mw_req_len);
                nb++;
            end
            if (mw_dat_valid && mw_dat_ready) begin
                mem[cur_word + beat] <= mw_dat;
                beat <= beat + 1;
                if (mw_dat_last) resp_cnt <= 3;
            end else if (resp_cnt > 1) begin
                resp_cnt <= resp_cnt - 1;
            end else if (resp_cnt == 1 && !hold_resp) begin
                resp_cnt <= 0;
            end
            mw_resp_valid <= (resp_cnt == 1) && !hold_resp;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        v = reg_rd_data;
    endtask

    task automatic feed(input int tag, input int n, output int acc);
        acc = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int start;
            int waitc;
            start    = hs_cnt;
            waitc    = 0;
            in_data  = {32'(tag), 32'(i + 1)};
            in_valid = 1'b1;
            while (hs_cnt == start && waitc < 80) begin
                @(negedge clk);
                waitc++;
            end
            if (hs_cnt == start) break;
            acc++;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        int acc;
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd2, rv);
        check(rv == 0, "R1 fullness", 64'(rv), 0);
        check(!in_ready && !mw_req_valid, "R1 idle", 64'({in_ready, mw_req_valid}), 0);
        feed(99, 1, acc);
        check(acc == 0, "R1 no accept before restart", 64'(acc), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int wrong;
            nb = 0;
            reg_write(2'd0, 32'(V_BASE[v]));
            reg_write(2'd1, 32'(V_SIZE[v]));
            reg_write(2'd2, 32'h1);
            feed(v + 1, V_OFFR[v], acc);
            idle(40);
            check(acc == V_WRDS[v], "R6 accepted words", 64'(acc), 64'(V_WRDS[v]));
            reg_read(2'd2, rv);
            check(int'(rv) == V_WRDS[v] * 8, "R5 R10 fullness", 64'(rv), 64'(V_WRDS[v] * 8));
            wrong = 0;
            for (int k = 0; k < V_WRDS[v]; k++)
                if (mem[(V_BASE[v] / 8) + k] != {32'(v + 1), 32'(k + 1)}) wrong++;
            check(wrong == 0, "R3 memory contents", 64'(wrong), 0);
            check(nb == V_NB[v], "R4 burst count", 64'(nb), 64'(V_NB[v]));
            check(blen[0] == V_FRST[v], "R4 first burst length", 64'(blen[0]), 64'(V_FRST[v]));
            check(!in_ready && !mw_req_valid, "R6 held off", 64'({in_ready, mw_req_valid}), 0);
        end

        // R8: shadow writes wait for restart (region at 0x3000 is full)
        reg_write(2'd1, 32'd16);
        reg_read(2'd1, rv);
        check(rv == 16, "R2 R8 size readback", 64'(rv), 16);
        reg_read(2'd0, rv);
        check(rv == 32'h3000, "R2 base readback", 64'(rv), 64'h3000);
        feed(20, 1, acc);
        check(acc == 0, "R8 no accept before restart", 64'(acc), 0);
        reg_read(2'd2, rv);
        check(rv == 24, "R8 fullness kept", 64'(rv), 24);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, rv);
        check(rv == 0, "R7 restart clears fullness", 64'(rv), 0);
        feed(21, 2, acc);
        idle(30);
        check(acc == 2, "R7 accepts after restart", 64'(acc), 2);
        check(mem[32'h3000 / 8] == {32'd21, 32'd1}, "R7 rewind to base",
              mem[32'h3000 / 8], {32'd21, 32'd1});

        // R5: fullness waits for the write response
        hold_resp = 1'b1;
        reg_write(2'd0, 32'h0000);
        reg_write(2'd1, 32'd32);
        reg_write(2'd2, 32'h1);
        feed(30, 4, acc);
        idle(10);
        reg_read(2'd2, rv);
        check(acc == 4 && rv == 0, "R5 no growth before response", 64'(rv), 0);
        hold_resp = 1'b0;
        idle(10);
        reg_read(2'd2, rv);
        check(rv == 32, "R5 growth on response", 64'(rv), 32);

        // R9: restart while a burst is outstanding
        hold_resp = 1'b1;
        reg_write(2'd0, 32'h3800);
        reg_write(2'd1, 32'd128);
        reg_write(2'd2, 32'h1);
        feed(40, 8, acc);
        check(acc == 8, "R9 burst accepted", 64'(acc), 8);
        reg_write(2'd0, 32'h0C00);
        reg_write(2'd1, 32'd16);
        reg_write(2'd2, 32'h1);
        idle(5);
        hold_resp = 1'b0;
        idle(20);
        check(mem[32'h3800 / 8 + 7] == {32'd40, 32'd8}, "R9 old burst completed",
              mem[32'h3800 / 8 + 7], {32'd40, 32'd8});
        reg_read(2'd2, rv);
        check(rv == 0, "R9 restart applied after response", 64'(rv), 0);
        feed(41, 2, acc);
        idle(30);
        check(mem[32'h0C00 / 8] == {32'd41, 32'd1}, "R9 new base in use",
              mem[32'h0C00 / 8], {32'd41, 32'd1});
        reg_read(2'd2, rv);
        check(rv == 16, "R7 fullness after new region", 64'(rv), 16);

        finish_run();
    end

endmodule